// File: doc/BRIEF.md
# Bus Address and I/O DMA Mapper

This block sits between an 8-bit-data peripheral bus with a 16-bit address and a 25-bit external memory. Every bus access goes out as a memory read or write request. A single 256-entry map table holds both kinds of translation. The lower half holds 512-byte page descriptors for memory accesses. The upper half holds two queue descriptors per device select: one for output and one for input.

A device select is captured from the bus data byte while chip-select is high. I/O strobes are ignored until a select has been captured. On I/O port 0, a descriptor with a nonzero byte count acts as a DMA queue. Each acknowledged transfer advances its address and reduces its count. Other ports, and port 0 once the count reaches zero, go to a fixed slot under a programmable base register. Firmware programs the table and the base register through a simple word-addressed CPU port.

Top module: `bus_io_mapper`

## Requirements
- R1: A high `bus_cs_i` captures `bus_data_i[5:0]` as the device select and marks it valid; bits [7:6] are ignored. `bus_rst_i` or `rst_ni` clears the valid mark. While no select is valid, I/O strobes raise no request.
- R2: A memory strobe uses entry `bus_addr_i[15:9]`. The request address is the entry address bits [24:9] followed by `bus_addr_i[8:0]`.
- R3: A read request needs the entry's read enable and a write request needs its write enable. Without the matching enable no request is raised. This applies to memory and I/O, including fallback slots.
- R4: An I/O strobe uses entry {1, select, dir}, with dir 1 for input and 0 for output. On port 0 (`bus_addr_i[2:0]`=0) with a nonzero count, the request address is the entry address.
- R5: An acknowledged port-0 DMA request writes the entry back with address+1 and count-1. This happens exactly once per strobe, and a count never goes below zero.
- R6: Any other port, or port 0 with count 0, requests {base[24:4], is_input, port[2:0]}. No write-back happens in this case.
- R7: A request holds until `ack_i`. It stays low for the rest of that strobe and is raised again by a new strobe.
- R8: CPU words 0-255 read and write {read enable at bit 31, write enable at bit 30, address [24:0]}. Words 256-511 hold the count in bits [8:0]. Word 512 holds the base in bits [24:4]. A write to one range leaves the other range untouched.
- R9: A CPU write to an output entry (even index >=128) never sets read enable. A CPU write to an input entry (odd index >=128) never sets write enable.
- R10: If a CPU write and a DMA write-back hit the same entry in the same cycle, the field the CPU wrote takes the CPU value. The other field takes the write-back value.
- R11: After reset the table and the base register read zero and no request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_rst_i | input | 1 | Bus reset, clears device select |
| bus_cs_i | input | 1 | Chip-select, captures select byte |
| bus_data_i | input | 8 | Bus data byte |
| bus_addr_i | input | 16 | Bus address; [2:0] is the I/O port |
| mem_rd_i | input | 1 | Memory read strobe |
| mem_wr_i | input | 1 | Memory write strobe |
| io_rd_i | input | 1 | I/O input strobe |
| io_wr_i | input | 1 | I/O output strobe |
| cpu_we_i | input | 1 | CPU write enable |
| cpu_addr_i | input | 10 | CPU word address |
| cpu_wdata_i | input | 32 | CPU write data |
| cpu_rdata_o | output | 32 | CPU read data (combinational) |
| req_rd_o | output | 1 | External memory read request |
| req_wr_o | output | 1 | External memory write request |
| req_addr_o | output | 25 | External memory address |
| ack_i | input | 1 | Request acknowledge |

## Verification
A DMA write-back and a CPU write can land on the same descriptor in the same clock. The bench provokes this by raising `ack_i` on a port-0 input transfer in the very cycle the CPU writes that entry. In one run the CPU writes the count word; in the other it writes the address word. Afterwards the bench reads both words back. It expects the CPU value in the field the CPU wrote and the incremented address or decremented count in the other field.

// File: rtl/bmap_pkg.sv
package bmap_pkg;
  localparam int ADDR_W   = 25;
  localparam int CNT_W    = 9;
  localparam int BUS_AW   = 16;
  localparam int BUS_DW   = 8;
  localparam int PAGE_W   = 9;
  localparam int SEL_W    = 6;
  localparam int PORT_W   = 3;
  localparam int IDX_W    = BUS_AW - PAGE_W + 1;
  localparam int N_ENT    = 1 << IDX_W;
  localparam int BASE_LSB = PORT_W + 1;
  localparam int CPU_AW   = IDX_W + 2;
  localparam int CPU_DW   = 32;
  localparam int RE_BIT   = 31;
  localparam int WE_BIT   = 30;

  typedef struct packed {
    logic [CNT_W-1:0]  cnt;
    logic              re;
    logic              we;
    logic [ADDR_W-1:0] addr;
  } map_ent_t;
endpackage

// File: rtl/bmap_sel_latch.sv
module bmap_sel_latch
  import bmap_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bus_rst_i,
  input  logic             cs_i,
  input  logic [BUS_DW-1:0] data_i,
  output logic [SEL_W-1:0] sel_o,
  output logic             vld_o
);
  logic unused_hi;
  assign unused_hi = ^data_i[BUS_DW-1:SEL_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_o <= '0;
      vld_o <= 1'b0;
    end else if (bus_rst_i) begin
      sel_o <= '0;
      vld_o <= 1'b0;
    end else if (cs_i) begin
      sel_o <= data_i[SEL_W-1:0];
      vld_o <= 1'b1;
    end
  end

  p_sel_clear_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rst_i |=> !vld_o);
endmodule

// File: rtl/bmap_table.sv
module bmap_table
  import bmap_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_idx_i,
  output map_ent_t         ent_o,
  input  logic             wb_i,
  input  logic             cpu_lo_we_i,
  input  logic             cpu_cnt_we_i,
  input  logic [IDX_W-1:0] cpu_idx_i,
  input  logic [CPU_DW-1:0] cpu_wdata_i,
  output map_ent_t         cpu_ent_o
);
  map_ent_t ent_all [N_ENT];

  for (genvar g = 0; g < N_ENT; g++) begin : g_ent
    localparam logic [IDX_W-1:0] IDX = IDX_W'(g);
    localparam bit IS_IO = IDX[IDX_W-1];
    localparam bit IS_IN = IDX[0];
    map_ent_t q;
    logic cpu_lo_hit, cpu_cnt_hit, wb_hit;
    assign cpu_lo_hit  = cpu_lo_we_i  && (cpu_idx_i == IDX);
    assign cpu_cnt_hit = cpu_cnt_we_i && (cpu_idx_i == IDX);
    assign wb_hit      = wb_i && (rd_idx_i == IDX);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        q <= '0;
      end else begin
        if (cpu_lo_hit) begin
          q.addr <= cpu_wdata_i[ADDR_W-1:0];
          q.re   <= cpu_wdata_i[RE_BIT] & ~(IS_IO & ~IS_IN);
          q.we   <= cpu_wdata_i[WE_BIT] & ~(IS_IO & IS_IN);
        end else if (wb_hit) begin
          q.addr <= q.addr + 1'b1;
        end
        if (cpu_cnt_hit)
          q.cnt <= cpu_wdata_i[CNT_W-1:0];
        else if (wb_hit)
          q.cnt <= q.cnt - 1'b1;
      end
    end
    assign ent_all[g] = q;
  end

  assign ent_o     = ent_all[rd_idx_i];
  assign cpu_ent_o = ent_all[cpu_idx_i];

  logic             chk_v_q;
  logic [IDX_W-1:0] chk_idx_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chk_v_q   <= 1'b0;
      chk_idx_q <= '0;
    end else begin
      chk_v_q   <= cpu_lo_we_i & cpu_idx_i[IDX_W-1];
      chk_idx_q <= cpu_idx_i;
    end
  end

  p_dir_mask_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_v_q |-> (chk_idx_q[0] ? !ent_all[chk_idx_q].we : !ent_all[chk_idx_q].re));

  p_cnt_nowrap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_i |-> (ent_o.cnt != '0));
endmodule

// File: rtl/bmap_addr_gen.sv
module bmap_addr_gen
  import bmap_pkg::*;
(
  input  logic                     io_i,
  input  logic                     rd_i,
  input  logic [BUS_AW-1:0]        bus_addr_i,
  input  map_ent_t                 ent_i,
  input  logic [ADDR_W-1:BASE_LSB] base_i,
  output logic [ADDR_W-1:0]        addr_o,
  output logic                     en_o,
  output logic                     dma_o
);
  logic [PORT_W-1:0] port;
  logic unused_hi;
  assign port      = bus_addr_i[PORT_W-1:0];
  assign unused_hi = ^bus_addr_i[BUS_AW-1:PAGE_W];

  assign dma_o = io_i && (port == '0) && (ent_i.cnt != '0);
  assign en_o  = rd_i ? ent_i.re : ent_i.we;

  always_comb begin
    if (!io_i)
      addr_o = {ent_i.addr[ADDR_W-1:PAGE_W], bus_addr_i[PAGE_W-1:0]};
    else if (dma_o)
      addr_o = ent_i.addr;
    else
      addr_o = {base_i, rd_i, port};
  end
endmodule

// File: rtl/bmap_req_ctrl.sv
module bmap_req_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic en_i,
  input  logic dma_i,
  input  logic ack_i,
  output logic req_o,
  output logic wb_o
);
  logic acked_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      acked_q <= 1'b0;
    else if (!active_i)
      acked_q <= 1'b0;
    else if (req_o && ack_i)
      acked_q <= 1'b1;
  end

  assign req_o = active_i & en_i & ~acked_q;
  assign wb_o  = req_o & ack_i & dma_i;

  p_req_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !ack_i) |=> (req_o || !active_i || !en_i));

  p_single_wb_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_o |=> !wb_o);
endmodule

// File: rtl/bus_io_mapper.sv
module bus_io_mapper
  import bmap_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_rst_i,
  input  logic              bus_cs_i,
  input  logic [BUS_DW-1:0] bus_data_i,
  input  logic [BUS_AW-1:0] bus_addr_i,
  input  logic              mem_rd_i,
  input  logic              mem_wr_i,
  input  logic              io_rd_i,
  input  logic              io_wr_i,
  input  logic              cpu_we_i,
  input  logic [CPU_AW-1:0] cpu_addr_i,
  input  logic [CPU_DW-1:0] cpu_wdata_i,
  output logic [CPU_DW-1:0] cpu_rdata_o,
  output logic              req_rd_o,
  output logic              req_wr_o,
  output logic [ADDR_W-1:0] req_addr_o,
  input  logic              ack_i
);
  logic [SEL_W-1:0] sel;
  logic             sel_vld;
  logic             io_act, mem_act, active, rd_dir;
  logic [IDX_W-1:0] idx;
  map_ent_t         ent, cpu_ent;
  logic             en, dma, req, wb;
  logic [ADDR_W-1:BASE_LSB] base_q;
  logic             base_sel, cnt_sel, lo_sel;
  logic [IDX_W-1:0] cpu_idx;
  logic             unused_wd;

  bmap_sel_latch u_sel (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bus_rst_i (bus_rst_i),
    .cs_i      (bus_cs_i),
    .data_i    (bus_data_i),
    .sel_o     (sel),
    .vld_o     (sel_vld)
  );

  assign io_act  = (io_rd_i | io_wr_i) & sel_vld;
  assign mem_act = (mem_rd_i | mem_wr_i) & ~(io_rd_i | io_wr_i);
  assign active  = io_act | mem_act;
  assign rd_dir  = io_act ? io_rd_i : mem_rd_i;
  assign idx     = io_act ? {1'b1, sel, io_rd_i} : {1'b0, bus_addr_i[BUS_AW-1:PAGE_W]};

  // CPU decode: [9] base register, [8] count range, else address/enables
  assign base_sel = cpu_addr_i[CPU_AW-1];
  assign cnt_sel  = ~cpu_addr_i[CPU_AW-1] & cpu_addr_i[CPU_AW-2];
  assign lo_sel   = ~cpu_addr_i[CPU_AW-1] & ~cpu_addr_i[CPU_AW-2];
  assign cpu_idx  = cpu_addr_i[IDX_W-1:0];
  assign unused_wd = ^cpu_wdata_i[WE_BIT-1:ADDR_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      base_q <= '0;
    else if (cpu_we_i && base_sel)
      base_q <= cpu_wdata_i[ADDR_W-1:BASE_LSB];
  end

  bmap_table u_table (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rd_idx_i     (idx),
    .ent_o        (ent),
    .wb_i         (wb),
    .cpu_lo_we_i  (cpu_we_i & lo_sel),
    .cpu_cnt_we_i (cpu_we_i & cnt_sel),
    .cpu_idx_i    (cpu_idx),
    .cpu_wdata_i  (cpu_wdata_i),
    .cpu_ent_o    (cpu_ent)
  );

  bmap_addr_gen u_agen (
    .io_i       (io_act),
    .rd_i       (rd_dir),
    .bus_addr_i (bus_addr_i),
    .ent_i      (ent),
    .base_i     (base_q),
    .addr_o     (req_addr_o),
    .en_o       (en),
    .dma_o      (dma)
  );

  bmap_req_ctrl u_req (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (active),
    .en_i     (en),
    .dma_i    (dma),
    .ack_i    (ack_i),
    .req_o    (req),
    .wb_o     (wb)
  );

  assign req_rd_o = req & rd_dir;
  assign req_wr_o = req & ~rd_dir;

  always_comb begin
    if (base_sel)
      cpu_rdata_o = {{(CPU_DW-ADDR_W){1'b0}}, base_q, {BASE_LSB{1'b0}}};
    else if (cnt_sel)
      cpu_rdata_o = {{(CPU_DW-CNT_W){1'b0}}, cpu_ent.cnt};
    else
      cpu_rdata_o = {cpu_ent.re, cpu_ent.we, {(WE_BIT-ADDR_W){1'b0}}, cpu_ent.addr};
  end

  p_no_io_unselected_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel_vld && !mem_rd_i && !mem_wr_i) |-> !(req_rd_o || req_wr_o));

  p_rd_wr_excl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_rd_o && req_wr_o));
endmodule

// File: tb/bus_io_mapper_tb.sv
module bus_io_mapper_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bus_rst = 1'b0, bus_cs = 1'b0;
  logic [7:0]  bus_data = '0;
  logic [15:0] bus_addr = '0;
  logic        mem_rd = 1'b0, mem_wr = 1'b0, io_rd = 1'b0, io_wr = 1'b0;
  logic        cpu_we = 1'b0;
  logic [9:0]  cpu_addr = '0;
  logic [31:0] cpu_wdata = '0;
  logic [31:0] cpu_rdata;
  logic        req_rd, req_wr, ack = 1'b0;
  logic [24:0] req_addr;
  int n_vec = 0, n_bad = 0;

  localparam logic [31:0] RE = 32'h8000_0000;
  localparam logic [31:0] WE = 32'h4000_0000;

  always #2 clk = ~clk;

  bus_io_mapper u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .bus_rst_i(bus_rst), .bus_cs_i(bus_cs),
    .bus_data_i(bus_data), .bus_addr_i(bus_addr), .mem_rd_i(mem_rd),
    .mem_wr_i(mem_wr), .io_rd_i(io_rd), .io_wr_i(io_wr), .cpu_we_i(cpu_we),
    .cpu_addr_i(cpu_addr), .cpu_wdata_i(cpu_wdata), .cpu_rdata_o(cpu_rdata),
    .req_rd_o(req_rd), .req_wr_o(req_wr), .req_addr_o(req_addr), .ack_i(ack)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic cpu_wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk); cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk); cpu_we = 1'b0;
  endtask

  task automatic cpu_rd(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk); cpu_addr = a; #1 d = cpu_rdata;
  endtask

  task automatic set_sel(input logic [5:0] s);
    @(negedge clk); bus_cs = 1'b1; bus_data = {2'b11, s};
    @(negedge clk); bus_cs = 1'b0; bus_data = '0;
  endtask

  // kind 0 = memory, 1 = I/O
  task automatic access(input bit kind, input bit rd, input logic [15:0] a,
                        input bit exp_req, input logic [24:0] exp_addr, input string tag);
    @(negedge clk);
    bus_addr = a;
    if (kind) begin io_rd = rd; io_wr = !rd; end
    else begin mem_rd = rd; mem_wr = !rd; end
    #1;
    chk({tag, " req"}, {30'd0, req_rd, req_wr}, exp_req ? (rd ? 32'd2 : 32'd1) : 32'd0);
    if (exp_req) begin
      chk({tag, " addr"}, {7'd0, req_addr}, {7'd0, exp_addr});
      @(negedge clk); #1;
      chk({tag, " R7 held before ack"}, {31'd0, req_rd | req_wr}, 32'd1);
      ack = 1'b1;
      @(negedge clk); ack = 1'b0; #1;
      chk({tag, " R7 dropped after ack"}, {31'd0, req_rd | req_wr}, 32'd0);
      @(negedge clk); #1;
      chk({tag, " R7 stays low in strobe"}, {31'd0, req_rd | req_wr}, 32'd0);
    end
    @(negedge clk);
    mem_rd = 0; mem_wr = 0; io_rd = 0; io_wr = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d, base_w;
    logic [24:0] pa, a0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R11 reset state
    #1 chk("R11 no request", {30'd0, req_rd, req_wr}, 0);
    cpu_rd(10'd5, d);   chk("R11 map word", d, 0);
    cpu_rd(10'd300, d); chk("R11 count word", d, 0);
    cpu_rd(10'd512, d); chk("R11 base", d, 0);

    // R8 base register
    base_w = 32'h00AB_CDE7;
    cpu_wr(10'd512, base_w);
    cpu_rd(10'd512, d); chk("R8 base readback", d, base_w & 32'h01FF_FFF0);

    // R2/R3 sweep of all memory pages
    for (int p = 0; p < 128; p++) begin
      pa = 25'(((p * 37 + 5) & 16'hFFFF) << 9);
      d = {7'd0, pa};
      if (p % 8 != 7) d |= RE;
      if ((p % 2 == 1) && (p % 8 != 7)) d |= WE;
      cpu_wr(10'(p), d);
    end
    for (int p = 0; p < 128; p++) begin
      logic [8:0] off;
      pa = 25'(((p * 37 + 5) & 16'hFFFF) << 9);
      off = 9'((p * 5) & 9'h1FF);
      access(0, 1, {7'(p), off}, p % 8 != 7, pa | 25'(off), "R2 mem read");
      access(0, 0, {7'(p), off}, (p % 2 == 1) && (p % 8 != 7), pa | 25'(off), "R3 mem write");
    end

    // R1 no valid select: I/O ignored
    access(1, 1, 16'h0000, 0, 0, "R1 io without select");

    // R4/R5/R6 DMA queue on select 0x2A, input direction (entry 213)
    a0 = 25'h123_4560;
    set_sel(6'h2A);
    cpu_wr(10'd213, RE | {7'd0, a0});
    cpu_wr(10'd256 + 10'd213, 32'd3);
    cpu_rd(10'd213, d); chk("R8 map word kept after count write", d, RE | {7'd0, a0});
    cpu_rd(10'd469, d); chk("R8 count readback", d, 3);
    for (int k = 0; k < 4; k++) begin
      if (k < 3) access(1, 1, 16'h0000, 1, a0 + 25'(k), "R4 port0 dma");
      else access(1, 1, 16'h0000, 1, {base_w[24:4], 1'b1, 3'd0}, "R6 exhausted fallback");
      cpu_rd(10'd469, d); chk("R5 count after transfer", d, (k < 3) ? 32'(2 - k) : 0);
      cpu_rd(10'd213, d); chk("R5 addr after transfer", d,
                              RE | {7'd0, a0 + 25'((k < 3) ? k + 1 : 3)});
    end
    cpu_wr(10'd469, 32'd4);
    access(1, 1, 16'h0005, 1, {base_w[24:4], 1'b1, 3'd5}, "R6 other port");
    cpu_rd(10'd469, d); chk("R6 no write-back on other port", d, 4);

    // R9 direction masking
    cpu_wr(10'd212, RE | WE | 32'h0000_1111);
    cpu_rd(10'd212, d); chk("R9 output entry drops read enable", d, WE | 32'h0000_1111);
    cpu_wr(10'd213, RE | WE | 32'h0000_2222);
    cpu_rd(10'd213, d); chk("R9 input entry drops write enable", d, RE | 32'h0000_2222);

    // R6/R3 output fallback, then gated by disabled entry
    access(1, 0, 16'h0006, 1, {base_w[24:4], 1'b0, 3'd6}, "R6 out fallback");
    cpu_wr(10'd212, 32'd0);
    access(1, 0, 16'h0006, 0, 0, "R3 io disabled entry");

    // R10 collision: CPU count write vs write-back
    cpu_wr(10'd213, RE | {7'd0, a0});
    cpu_wr(10'd469, 32'd5);
    @(negedge clk);
    bus_addr = 16'h0; io_rd = 1; ack = 1; cpu_we = 1; cpu_addr = 10'd469; cpu_wdata = 32'd9;
    @(negedge clk); ack = 0; cpu_we = 0;
    @(negedge clk); io_rd = 0;
    cpu_rd(10'd469, d); chk("R10 cpu count wins", d, 9);
    cpu_rd(10'd213, d); chk("R10 addr from write-back", d, RE | {7'd0, a0 + 25'd1});
    // R10 collision: CPU address write vs write-back
    @(negedge clk);
    bus_addr = 16'h0; io_rd = 1; ack = 1; cpu_we = 1; cpu_addr = 10'd213;
    cpu_wdata = RE | 32'h0000_0777;
    @(negedge clk); ack = 0; cpu_we = 0;
    @(negedge clk); io_rd = 0;
    cpu_rd(10'd213, d); chk("R10 cpu addr wins", d, RE | 32'h0000_0777);
    cpu_rd(10'd469, d); chk("R10 count from write-back", d, 8);

    // R4/R5 sweep over every select, single-entry queues
    for (int s = 0; s < 64; s++) begin
      cpu_wr(10'(128 + 2 * s + 1), RE | 32'(s * 1000 + 7));
      cpu_wr(10'(256 + 128 + 2 * s + 1), 32'd1);
    end
    for (int s = 0; s < 64; s++) begin
      set_sel(6'(s));
      access(1, 1, 16'h0000, 1, 25'(s * 1000 + 7), "R4 select sweep");
      cpu_rd(10'(256 + 128 + 2 * s + 1), d); chk("R5 select sweep count", d, 0);
    end

    // R1 bus reset clears select
    @(negedge clk); bus_rst = 1;
    @(negedge clk); bus_rst = 0;
    access(1, 1, 16'h0003, 0, 0, "R1 io after bus reset");

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule